// File: doc/BRIEF.md
# Serial debug port controller

This block is the processor-side end of a debug link. An external tool talks to it over a full-duplex clocked serial port: every bit the tool shifts in is matched by one bit shifted out. The block keeps a debug-mode flag and sets it in one of two ways. The first is strapping: the serial clock level while reset is held decides whether the core comes out of reset already in debug mode. The second is a core exception whose cause code is enabled in a programmable mask. When an exception puts the core into debug mode, its cause is latched, and the tool can read it back over the port.

Alongside the port, the block watches the core's address bus. It has two watchpoint comparators, each driving its own flag pin, and one breakpoint comparator, which requests an exception from the core. The comparators check every cycle at full bus rate and never stall the bus. The bus interface only observes and has no ready signal, so the block applies no back-pressure. The exception request and cause input is a plain strobe with no back-pressure. Each request is answered one cycle later by exactly one of two pulses: either it was taken into debug mode, or it goes on to normal handling.

Frames are 32 bits long and are sent MSB first. The command sits in bits 31:28 and the data in bits 27:0. Every frame's reply is shifted out during the following frame.

Top module: `sdp_ctrl`

## Requirements
- R1: If the serial clock is low while reset is held, then after reset `dbg_mode`, `wp_flag`, `brk_req`, `exc_dbg` and `exc_normal` are all 0.
- R2: If the serial clock is high while reset is held, then `dbg_mode` is 1 after reset and the latched cause is not valid.
- R3: Serial data is sampled on rising serial-clock edges, and `ser_dout` changes only after falling edges. The reply to any frame other than read-status is that same 32-bit frame word, shifted out MSB first during the next frame. Codes 0 and 7..15 are no-operations.
- R4: Command 1 (read status) returns the following word in the next frame: bit 31 = debug mode, bit 30 = cause valid, bits 19:16 = latched cause, bits 15:0 = exception mask, all other bits 0.
- R5: An exception request whose cause bit is clear in the mask, or one that arrives while debug mode is already set, produces a one-cycle `exc_normal` pulse in the next cycle and leaves `dbg_mode` unchanged.
- R6: An exception request whose cause bit is set in the mask, arriving while not in debug mode, produces a one-cycle `exc_dbg` pulse in the next cycle. It also sets `dbg_mode` and latches the cause with cause-valid set.
- R7: Command 6 (exit debug) clears `dbg_mode`, cause-valid and the latched cause.
- R8: Command 2+n (n = 0, 1) writes watchpoint n: bit 27 is the enable and bits 23:0 are the address. `wp_flag[n]` pulses for one cycle, one cycle after each valid bus access to an enabled, matching address. Command 5 writes the exception mask from bits 15:0.
- R9: Command 4 writes the breakpoint comparator, with the same field layout as R8. `brk_req` pulses one cycle after each valid matching access, including back-to-back cycles.
- R10: After reset all comparators are disabled and the mask is zero. A valid access to address 0 raises no flag, and status reports mask 0.
- R11: A comparator whose enable bit is written 0, or an access with `bus_valid` low, raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the debug tool (also the reset strap) |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial data to the debug tool |
| exc_req | input | 1 | Core exception request strobe |
| exc_cause | input | 4 | Cause code of the exception request |
| exc_dbg | output | 1 | Pulse: exception taken into debug mode |
| exc_normal | output | 1 | Pulse: exception left to normal handling |
| bus_valid | input | 1 | Core bus access valid |
| bus_addr | input | 24 | Core bus address |
| wp_flag | output | 2 | Watchpoint match pulses |
| brk_req | output | 1 | Breakpoint exception request to the core |
| dbg_mode | output | 1 | Debug mode active |

## Verification
The comparators are driven with random accesses. The addresses are drawn mostly from the three programmed values and partly from random ones, and `bus_valid` is random. This separates the per-comparator address match, the valid qualification and the single-cycle width of the pulse. The serial path carries directed configuration frames mixed with random no-operation frames. Comparing each echo in the following frame exposes bit order, bit loss at frame boundaries, and wrong rising- or falling-edge use. Exceptions are applied with enabled and disabled causes, and again while already in debug mode. Together with the two reset strap levels and exit, these separate the debug-entry conditions from normal passing.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int FRAME_W = 32;
  localparam int CMD_LSB = 28;
  localparam int EN_BIT  = 27;

  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_STATUS = 4'd1,
    CMD_WP0    = 4'd2,
    CMD_WP1    = 4'd3,
    CMD_BRK    = 4'd4,
    CMD_MASK   = 4'd5,
    CMD_EXIT   = 4'd6
  } sdp_cmd_e;
endpackage

// File: rtl/sdp_serial.sv
module sdp_serial #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_din,
  input  logic [FRAME_W-1:0] reply_word,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word,
  output logic               ser_dout
);
  localparam int CNT_W = $clog2(FRAME_W);

  // Synchronisers are not reset so the strap level is tracked through reset.
  logic [1:0] clk_sync, din_sync;
  logic       clk_prev;
  always_ff @(posedge clk) begin
    clk_sync <= {clk_sync[0], ser_clk};
    din_sync <= {din_sync[0], ser_din};
    clk_prev <= clk_sync[1];
  end

  logic rise, fall;
  assign rise = clk_sync[1] & ~clk_prev;
  assign fall = ~clk_sync[1] & clk_prev;

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx_sh, tx_sh;
  logic               tx_hold;
  logic               last_bit;

  assign last_bit   = (bit_cnt == CNT_W'(FRAME_W - 1));
  assign frame_word = {rx_sh[FRAME_W-2:0], din_sync[1]};
  assign frame_vld  = rise & last_bit;
  assign ser_dout   = tx_sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (rise) begin
      rx_sh   <= frame_word;
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
    end
  end

  // The fall that follows a reply load keeps the MSB on the line for the next rise.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_hold <= 1'b1;
    end else if (frame_vld) begin
      tx_sh   <= reply_word;
      tx_hold <= 1'b1;
    end else if (fall) begin
      if (tx_hold) tx_hold <= 1'b0;
      else         tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
    end
  end

  // R3
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> $past(frame_vld || fall));
endmodule

// File: rtl/sdp_addr_cmp.sv
module sdp_addr_cmp #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else if (cfg_we) begin
      en_q   <= cfg_en;
      addr_q <= cfg_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= bus_valid && en_q && (bus_addr == addr_q);
  end

  // R11
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(bus_valid && en_q));
endmodule

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_WP  = 2,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_din,
  output logic               ser_dout,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  output logic               exc_dbg,
  output logic               exc_normal,
  input  logic               bus_valid,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic [NUM_WP-1:0]  wp_flag,
  output logic               brk_req,
  output logic               dbg_mode
);
  localparam int NUM_CAUSE = 1 << CAUSE_W;
  localparam int STAT_MODE = FRAME_W - 1;
  localparam int STAT_CV   = FRAME_W - 2;
  localparam int STAT_CAU  = 16;

  logic               frame_vld;
  logic [FRAME_W-1:0] frame_word;
  logic [FRAME_W-1:0] reply_word;
  logic [3:0]         cmd;
  logic               cfg_en;
  logic [ADDR_W-1:0]  cfg_addr;

  assign cmd      = frame_word[FRAME_W-1:CMD_LSB];
  assign cfg_en   = frame_word[EN_BIT];
  assign cfg_addr = frame_word[ADDR_W-1:0];

  sdp_serial #(.FRAME_W(FRAME_W)) u_serial (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .reply_word (reply_word),
    .frame_vld  (frame_vld),
    .frame_word (frame_word),
    .ser_dout   (ser_dout)
  );

  logic [NUM_WP-1:0] wp_hit;
  genvar gi;
  generate
    for (gi = 0; gi < NUM_WP; gi++) begin : g_wp
      logic we;
      assign we = frame_vld && (cmd == 4'(CMD_WP0) + 4'(gi));
      sdp_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (we),
        .cfg_en    (cfg_en),
        .cfg_addr  (cfg_addr),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .hit       (wp_hit[gi])
      );
    end
  endgenerate
  assign wp_flag = wp_hit;

  logic brk_we;
  assign brk_we = frame_vld && (cmd == CMD_BRK);
  sdp_addr_cmp #(.ADDR_W(ADDR_W)) u_brk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (brk_we),
    .cfg_en    (cfg_en),
    .cfg_addr  (cfg_addr),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .hit       (brk_req)
  );

  logic [NUM_CAUSE-1:0] exc_mask;
  logic [CAUSE_W-1:0]   cause_q;
  logic                 cause_vld;
  logic                 take;

  assign take = exc_req && exc_mask[exc_cause] && !dbg_mode;

  // Strap: the serial clock level seen during reset selects the initial mode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_mode   <= ser_clk;
      cause_q    <= '0;
      cause_vld  <= 1'b0;
      exc_mask   <= '0;
      exc_dbg    <= 1'b0;
      exc_normal <= 1'b0;
    end else begin
      exc_dbg    <= take;
      exc_normal <= exc_req && !take;
      if (frame_vld && cmd == CMD_MASK) exc_mask <= frame_word[NUM_CAUSE-1:0];
      if (frame_vld && cmd == CMD_EXIT) begin
        dbg_mode  <= 1'b0;
        cause_vld <= 1'b0;
        cause_q   <= '0;
      end
      if (take) begin
        dbg_mode  <= 1'b1;
        cause_vld <= 1'b1;
        cause_q   <= exc_cause;
      end
    end
  end

  logic [FRAME_W-1:0] status_word;
  always_comb begin
    status_word                        = '0;
    status_word[STAT_MODE]             = dbg_mode;
    status_word[STAT_CV]               = cause_vld;
    status_word[STAT_CAU +: CAUSE_W]   = cause_q;
    status_word[0 +: NUM_CAUSE]        = exc_mask;
    reply_word = (cmd == CMD_STATUS) ? status_word : frame_word;
  end

  // R6
  dbg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_mode) |-> $past(exc_req) && exc_dbg);
  // R7
  exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && cmd == CMD_EXIT && !exc_req) |=> (!dbg_mode && !cause_vld));
  // R5
  normal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_normal |-> ($past(exc_req) && !exc_dbg));
endmodule

// File: tb/sdp_ctrl_test.sv
module sdp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n, ser_clk, ser_din, exc_req, bus_valid;
  logic [3:0]  exc_cause;
  logic [23:0] bus_addr;
  logic        ser_dout, exc_dbg, exc_normal, brk_req, dbg_mode;
  logic [1:0]  wp_flag;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  sdp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_dbg(exc_dbg), .exc_normal(exc_normal), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .wp_flag(wp_flag), .brk_req(brk_req),
    .dbg_mode(dbg_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp(input bit m, input bit cv, input logic [3:0] c, input logic [15:0] msk);
    logic [31:0] w = '0;
    w[31] = m; w[30] = cv; w[19:16] = c; w[15:0] = msk;
    return w;
  endfunction

  function automatic logic [31:0] cmp_word(input logic [3:0] cmd, input bit en, input logic [23:0] a);
    return {cmd, en, 3'b000, a};
  endfunction

  task automatic do_reset(input bit strap);
    rst_n = 1'b0; ser_clk = strap; ser_din = 1'b0;
    exc_req = 1'b0; exc_cause = '0; bus_valid = 1'b0; bus_addr = '0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ser_clk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] tx, output logic [31:0] rx);
    for (int i = 31; i >= 0; i--) begin
      ser_din = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = ser_dout;
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_exc(input logic [3:0] c);
    exc_req = 1'b1; exc_cause = c;
    @(negedge clk);
    exc_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rx, prev, w;
    logic [23:0] a0, a1, ab;
    logic [15:0] msk;
    bit e0, e1, eb, v;
    logic [23:0] ad;
    void'($urandom(32'h5D17));

    do_reset(1'b0);
    chk(dbg_mode == 0 && wp_flag == 0 && !brk_req && !exc_dbg && !exc_normal,
        "R1 reset outputs", {27'b0, dbg_mode, wp_flag, brk_req, exc_dbg}, 32'h0);
    bus_valid = 1'b1; bus_addr = '0;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(wp_flag == 0 && !brk_req, "R10 disabled after reset", {29'b0, wp_flag, brk_req}, 32'h0);
    xfer(32'h1000_0000, rx);
    xfer(32'h0000_0000, rx);
    chk(rx == stat_exp(0, 0, 0, 0), "R10 R4 reset status", rx, stat_exp(0, 0, 0, 0));

    // random no-op frames echo in the next frame
    prev = 32'h0;
    for (int k = 0; k < 6; k++) begin
      w = $urandom;
      if (w[31:28] >= 4'd1 && w[31:28] <= 4'd6) w[31:28] = 4'd0;
      xfer(w, rx);
      chk(rx == prev, "R3 echo", rx, prev);
      prev = w;
    end

    a0 = 24'h00_1000 | 24'($urandom % 1024);
    a1 = 24'h20_0000 | 24'($urandom % 1024);
    ab = 24'h40_0000 | 24'($urandom % 1024);
    xfer(cmp_word(4'd2, 1, a0), rx);
    chk(rx == prev, "R3 echo before config", rx, prev);
    xfer(cmp_word(4'd3, 1, a1), rx);
    chk(rx == cmp_word(4'd2, 1, a0), "R3 R8 wp0 write echo", rx, cmp_word(4'd2, 1, a0));
    xfer(cmp_word(4'd4, 1, ab), rx);
    chk(rx == cmp_word(4'd3, 1, a1), "R3 R8 wp1 write echo", rx, cmp_word(4'd3, 1, a1));

    for (int k = 0; k < 300; k++) begin
      v = 1'($urandom);
      case ($urandom % 4)
        0: ad = a0;
        1: ad = a1;
        2: ad = ab;
        default: ad = 24'($urandom);
      endcase
      bus_valid = v; bus_addr = ad;
      e0 = v && ad == a0; e1 = v && ad == a1; eb = v && ad == ab;
      @(negedge clk);
      chk(wp_flag == {e1, e0}, "R8 watchpoint flags", {30'b0, wp_flag}, {30'b0, e1, e0});
      chk(brk_req == eb, "R9 breakpoint request", {31'b0, brk_req}, {31'b0, eb});
    end
    // back-to-back breakpoint hits, then idle
    bus_valid = 1'b1; bus_addr = ab;
    @(negedge clk);
    chk(brk_req, "R9 back-to-back first", {31'b0, brk_req}, 32'h1);
    @(negedge clk);
    chk(brk_req, "R9 back-to-back second", {31'b0, brk_req}, 32'h1);
    bus_valid = 1'b0;
    @(negedge clk);
    chk(!brk_req && wp_flag == 0, "R11 valid low no flag", {29'b0, wp_flag, brk_req}, 32'h0);

    // disable watchpoint 1
    xfer(cmp_word(4'd3, 0, a1), rx);
    bus_valid = 1'b1; bus_addr = a1;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(wp_flag == 0, "R11 disabled comparator", {30'b0, wp_flag}, 32'h0);

    // exception mask: causes 3 and 9 enabled
    msk = 16'h0208;
    xfer({4'd5, 12'h000, msk}, rx);
    pulse_exc(4'd5);
    chk(exc_normal && !exc_dbg && !dbg_mode, "R5 masked exception passes",
        {29'b0, exc_normal, exc_dbg, dbg_mode}, 32'h4);
    @(negedge clk);
    chk(!exc_normal, "R5 pulse one cycle", {31'b0, exc_normal}, 32'h0);
    pulse_exc(4'd9);
    chk(exc_dbg && !exc_normal && dbg_mode, "R6 enabled exception enters debug",
        {29'b0, exc_normal, exc_dbg, dbg_mode}, 32'h3);
    @(negedge clk);
    chk(!exc_dbg && dbg_mode, "R6 pulse one cycle, mode held", {30'b0, exc_dbg, dbg_mode}, 32'h1);
    pulse_exc(4'd3);
    chk(exc_normal && !exc_dbg, "R5 exception while in debug", {30'b0, exc_normal, exc_dbg}, 32'h2);
    xfer(32'h1000_0000, rx);
    xfer(32'h0000_0000, rx);
    chk(rx == stat_exp(1, 1, 4'd9, msk), "R4 R6 status cause latched", rx, stat_exp(1, 1, 4'd9, msk));

    xfer(32'h6000_0000, rx);
    chk(!dbg_mode, "R7 exit clears mode", {31'b0, dbg_mode}, 32'h0);
    xfer(32'h1000_0000, rx);
    xfer(32'h0000_0000, rx);
    chk(rx == stat_exp(0, 0, 0, msk), "R7 status after exit", rx, stat_exp(0, 0, 0, msk));

    do_reset(1'b1);
    chk(dbg_mode, "R2 strap high enters debug", {31'b0, dbg_mode}, 32'h1);
    xfer(32'h1000_0000, rx);
    xfer(32'h0000_0000, rx);
    chk(rx == stat_exp(1, 0, 0, 0), "R2 R10 strap status", rx, stat_exp(1, 0, 0, 0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule